// File: doc/BRIEF.md
# Data Strobe and Mask Mode Driver

This block produces the per-pin output enable and differential levels for eighteen data strobe pins of a DRAM data interface, together with the read-capture enables that decide which strobe latches which 4-bit data group. A single mode input picks the device width. In narrow (x4) mode every strobe is a true strobe. It toggles while its write window is open, and it captures its own nibble on reads. In wide (x8) mode the upper nine strobes become data mask pins. They open and close on exactly the same cycles as before, but they hold a fixed differential level, and read capture no longer uses them.

Each strobe has a write-window input, which already contains its preamble and postamble cycles, and a read-window input. All outputs are registered and appear one clock after the inputs that cause them. A bank of nibble enables also routes each of the eighteen data/check nibbles to the strobe that captures it in the current mode.

Top module: `dqs_mask_driver`

## Requirements
- R1: `dqs_oe[i]` equals `wr_win[i]` of the previous cycle for every strobe, in both modes.
- R2: A strobe acting as a true strobe drives `dqs_p=0, dqs_n=1` in the first driven cycle of a window. It then inverts both legs every cycle, and the legs are always complementary while driven.
- R3: When `wide_mode=1` was sampled, strobes 9 to 17 that are driven output `dqs_p=0, dqs_n=1` in every cycle of the window.
- R4: Strobes 0 to 8 behave as true strobes (R2) in both modes.
- R5: While `dqs_oe[i]=0`, both `dqs_p[i]` and `dqs_n[i]` are 0.
- R6: `cap_en[i]` equals the previous cycle's `rd_win[i]`, except that it is 0 for strobes 9 to 17 when `wide_mode=1` was sampled.
- R7: With `wide_mode=0`, nibble k (data bits 4k+3:4k for k<16, check bits for k=16,17) is captured by strobe k/2 when k is even and by strobe k/2+9 when k is odd. So strobe 16 takes data bits 63:60, strobe 8 takes check bits 3:0 and strobe 17 takes check bits 7:4. `nib_cap_en[k]` is that strobe's previous-cycle `rd_win`.
- R8: With `wide_mode=1`, nibbles 2j and 2j+1 are both captured by strobe j, so strobe 8 takes all check bits 7:0. `nib_cap_en[k]` is `rd_win[k/2]` of the previous cycle.
- R9: During and right after reset, all outputs are 0 and every toggle phase is cleared.
- R10: A window that closes for one or more cycles restarts its toggle sequence from the low phase.
- R11: The toggle phase of an upper strobe keeps advancing while it acts as a mask pin. If the mode changes inside an open window, that strobe resumes toggling at the phase its window has reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 0 = x4 mode, 1 = x8 mode (upper strobes as mask) |
| wr_win | input | 18 | Per-strobe write drive window, including preamble and postamble |
| rd_win | input | 18 | Per-strobe read capture window |
| dqs_p | output | 18 | Positive leg level |
| dqs_n | output | 18 | Negative leg level |
| dqs_oe | output | 18 | Per-pin output enable (0 = tri-stated) |
| cap_en | output | 18 | Per-strobe read-capture enable |
| nib_cap_en | output | 18 | Per-nibble capture enable through the mode's strobe mapping |

## Verification
The toggle sequencing and the mask-level override both act on strobes 9 to 17 in the same cycle whenever `wide_mode` flips while their write windows stay open. The bench forces that case directly, with long windows held across a mode flip in each direction, and also reaches it through random mode changes. The legs are judged against a bench model whose phase advances regardless of mode. The same mode flips hit read-capture gating and nibble routing together, and both outputs are compared each cycle against the bench's own mapping.

// File: rtl/dqs_pkg.sv
package dqs_pkg;

    // One strobe pin as seen at the pad: enable plus two legs.
    typedef struct packed {
        logic oe;
        logic p;
        logic n;
    } pin_drive_t;

    typedef enum logic {
        ROLE_STROBE = 1'b0,
        ROLE_MASK   = 1'b1
    } lane_role_t;

    localparam pin_drive_t PIN_IDLE = '{oe: 1'b0, p: 1'b0, n: 1'b0};

    // Which strobe captures nibble k, given the count of strobes per half.
    function automatic int unsigned nib_strobe(input int unsigned k,
                                               input int unsigned half,
                                               input logic wide);
        int unsigned j;
        j = k / 2;
        if (!wide && (k % 2 == 1))
            return j + half;
        return j;
    endfunction

    // Level driven on an enabled pin for a role and phase.
    function automatic pin_drive_t drive_level(input lane_role_t role,
                                               input logic phase);
        pin_drive_t d;
        d.oe = 1'b1;
        if (role == ROLE_MASK) begin
            d.p = 1'b0;
            d.n = 1'b1;
        end else begin
            d.p = phase;
            d.n = ~phase;
        end
        return d;
    endfunction

endpackage

// File: rtl/dqs_lane.sv
module dqs_lane
    import dqs_pkg::*;
#(
    parameter bit MASK_CAPABLE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wide_mode,
    input  logic       wr_win,
    input  logic       rd_win,
    output pin_drive_t pin,
    output logic       cap
);
    logic       phase_q;
    lane_role_t role;

    generate
        if (MASK_CAPABLE) begin : g_mask
            assign role = wide_mode ? ROLE_MASK : ROLE_STROBE;
        end else begin : g_strobe
            assign role = ROLE_STROBE;
        end
    endgenerate

    // The phase advances whenever the window is open, whatever the role.
    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= 1'b0;
        else if (wr_win)
            phase_q <= ~phase_q;
        else
            phase_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= PIN_IDLE;
            cap <= 1'b0;
        end else begin
            pin <= wr_win ? drive_level(role, phase_q) : PIN_IDLE;
            cap <= rd_win && (role == ROLE_STROBE);
        end
    end
endmodule

// File: rtl/nibble_router.sv
module nibble_router
    import dqs_pkg::*;
#(
    parameter int unsigned NUM_LANES = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wide_mode,
    input  logic [NUM_LANES-1:0] rd_win,
    output logic [NUM_LANES-1:0] nib_en
);
    localparam int unsigned HALF = NUM_LANES / 2;

    logic [NUM_LANES-1:0] route_d;

    generate
        for (genvar k = 0; k < NUM_LANES; k++) begin : g_nib
            localparam int unsigned S_NARROW = nib_strobe(k, HALF, 1'b0);
            localparam int unsigned S_WIDE   = nib_strobe(k, HALF, 1'b1);
            assign route_d[k] = wide_mode ? rd_win[S_WIDE] : rd_win[S_NARROW];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            nib_en <= '0;
        else
            nib_en <= route_d;
    end
endmodule

// File: rtl/dqs_mask_driver.sv
module dqs_mask_driver
    import dqs_pkg::*;
#(
    parameter int unsigned NUM_LANES = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wide_mode,
    input  logic [NUM_LANES-1:0] wr_win,
    input  logic [NUM_LANES-1:0] rd_win,
    output logic [NUM_LANES-1:0] dqs_p,
    output logic [NUM_LANES-1:0] dqs_n,
    output logic [NUM_LANES-1:0] dqs_oe,
    output logic [NUM_LANES-1:0] cap_en,
    output logic [NUM_LANES-1:0] nib_cap_en
);
    localparam int unsigned HALF = NUM_LANES / 2;

    pin_drive_t pins [NUM_LANES];

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            dqs_lane #(
                .MASK_CAPABLE(i >= HALF)
            ) u_lane (
                .clk       (clk),
                .rst       (rst),
                .wide_mode (wide_mode),
                .wr_win    (wr_win[i]),
                .rd_win    (rd_win[i]),
                .pin       (pins[i]),
                .cap       (cap_en[i])
            );
            assign dqs_oe[i] = pins[i].oe;
            assign dqs_p[i]  = pins[i].p;
            assign dqs_n[i]  = pins[i].n;
        end
    endgenerate

    nibble_router #(
        .NUM_LANES(NUM_LANES)
    ) u_router (
        .clk       (clk),
        .rst       (rst),
        .wide_mode (wide_mode),
        .rd_win    (rd_win),
        .nib_en    (nib_cap_en)
    );
endmodule

// File: rtl/dqs_mask_driver_chk.sv
module dqs_mask_driver_chk #(
    parameter int unsigned NUM_LANES = 18
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wide_mode,
    input logic [NUM_LANES-1:0] wr_win,
    input logic [NUM_LANES-1:0] rd_win,
    input logic [NUM_LANES-1:0] dqs_p,
    input logic [NUM_LANES-1:0] dqs_n,
    input logic [NUM_LANES-1:0] dqs_oe,
    input logic [NUM_LANES-1:0] cap_en,
    input logic [NUM_LANES-1:0] nib_cap_en
);
    localparam int unsigned HALF = NUM_LANES / 2;

    AST_OE_TRACKS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> dqs_oe == $past(wr_win)); // R1

    AST_CAP_UPPER_GATED: assert property (@(posedge clk) disable iff (rst)
        wide_mode |=> cap_en[NUM_LANES-1:HALF] == '0); // R6

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_chk
            AST_IDLE_LEGS_LOW: assert property (@(posedge clk) disable iff (rst)
                !dqs_oe[i] |-> (!dqs_p[i] && !dqs_n[i])); // R5

            AST_FIRST_PHASE_LOW: assert property (@(posedge clk) disable iff (rst)
                $rose(dqs_oe[i]) |-> (!dqs_p[i] && dqs_n[i])); // R2

            if (i >= HALF) begin : g_up
                AST_MASK_LEVEL_FIXED: assert property (@(posedge clk) disable iff (rst)
                    (wide_mode && wr_win[i]) |=> (!dqs_p[i] && dqs_n[i])); // R3
            end else begin : g_lo
                AST_LOWER_TOGGLES: assert property (@(posedge clk) disable iff (rst)
                    (dqs_oe[i] && $past(dqs_oe[i])) |-> (dqs_p[i] != $past(dqs_p[i]) && dqs_n[i] == !dqs_p[i])); // R4
            end
        end
    endgenerate
endmodule

bind dqs_mask_driver dqs_mask_driver_chk #(.NUM_LANES(NUM_LANES)) u_chk (.*);

// File: tb/dqs_mask_driver_test.sv
module dqs_mask_driver_test;
    localparam int N = 18;
    localparam int H = N / 2;
    localparam time CLK_PERIOD = 10ns;
    localparam int RAND_CYCLES = 3000;

    logic clk = 1'b0;
    logic rst;
    logic wide_mode;
    logic [N-1:0] wr_win, rd_win;
    logic [N-1:0] dqs_p, dqs_n, dqs_oe, cap_en, nib_cap_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model state
    logic [N-1:0] m_phase;
    logic [N-1:0] e_p, e_n, e_oe, e_cap, e_nib;

    dqs_mask_driver #(.NUM_LANES(N)) uut (
        .clk(clk), .rst(rst), .wide_mode(wide_mode),
        .wr_win(wr_win), .rd_win(rd_win),
        .dqs_p(dqs_p), .dqs_n(dqs_n), .dqs_oe(dqs_oe),
        .cap_en(cap_en), .nib_cap_en(nib_cap_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int cap_strobe(input int k, input logic wide);
        if (wide) return k / 2;        // R8
        if (k % 2 == 1) return k / 2 + H; // R7
        return k / 2;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compute expected registered outputs from the inputs now applied.
    task automatic model_step();
        for (int i = 0; i < N; i++) begin
            e_oe[i] = wr_win[i];
            if (!wr_win[i]) begin
                e_p[i] = 1'b0; e_n[i] = 1'b0;
            end else if (wide_mode && i >= H) begin
                e_p[i] = 1'b0; e_n[i] = 1'b1;
            end else begin
                e_p[i] = m_phase[i]; e_n[i] = ~m_phase[i];
            end
            e_cap[i] = rd_win[i] && !(wide_mode && i >= H);
            m_phase[i] = wr_win[i] ? ~m_phase[i] : 1'b0;
        end
        for (int k = 0; k < N; k++)
            e_nib[k] = rd_win[cap_strobe(k, wide_mode)];
    endtask

    task automatic cycle_and_check();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check("R1 oe", dqs_oe, e_oe);
        check("R2/R4/R5 lower p", dqs_p[H-1:0], e_p[H-1:0]);
        check("R3/R11/R5 upper p", dqs_p[N-1:H], e_p[N-1:H]);
        check("R2/R3 n legs", dqs_n, e_n);
        check("R6 cap_en", cap_en, e_cap);
        check(wide_mode ? "R8 nib_cap_en" : "R7 nib_cap_en", nib_cap_en, e_nib);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; wide_mode = 1'b0; wr_win = '1; rd_win = '1;
        m_phase = '0;
        repeat (3) @(negedge clk);
        // R9: reset holds everything low
        check("R9 reset oe", dqs_oe, '0);
        check("R9 reset legs", dqs_p | dqs_n, '0);
        check("R9 reset cap", cap_en | nib_cap_en, '0);
        rst = 1'b0; wr_win = '0; rd_win = '0;

        // Directed R2/R4: x4 long window, all lanes toggle from low
        wr_win = '1; rd_win = '1;
        repeat (6) cycle_and_check();
        // R10: close for one cycle, then reopen: phase restarts low
        wr_win = '0; cycle_and_check();
        wr_win = '1; cycle_and_check();
        check("R10 restart low", dqs_p, '0);
        cycle_and_check();
        // R11: switch to x8 mid-window, hold, switch back
        wide_mode = 1'b1; repeat (3) cycle_and_check();
        wide_mode = 1'b0; repeat (3) cycle_and_check();
        // R3/R8: x8 with fresh window and full read
        wr_win = '0; cycle_and_check();
        wide_mode = 1'b1; wr_win = '1; rd_win = '1;
        repeat (4) cycle_and_check();
        // R8: single-strobe read to see mapping (strobe 8 covers check nibbles)
        rd_win = 18'h00100; cycle_and_check();
        wide_mode = 1'b0; cycle_and_check();  // R7: strobe 8 -> nibble 16 only
        rd_win = 18'h20000; cycle_and_check(); // R7: strobe 17 -> nibble 17
        rd_win = 18'h10000; cycle_and_check(); // R7: strobe 16 -> nibble 15

        // Random phase
        for (int c = 0; c < RAND_CYCLES; c++) begin
            if ($urandom_range(7) == 0) wide_mode = ~wide_mode;
            for (int i = 0; i < N; i++)
                if ($urandom_range(3) == 0) wr_win[i] = ~wr_win[i];
            rd_win = N'($urandom);
            cycle_and_check();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule